// File: doc/BRIEF.md
# Two-Cycle Ternary Bit-Manipulation Unit

This block is a 32-bit execution unit for bit-manipulation operations that take three source operands, and for rotates. It supports conditional mix, conditional move, funnel shift left and right, and rotate left and right. Each operation finishes in exactly two clock cycles.

The first cycle writes a partial result into one internal stage register. The second cycle combines that partial result with a second pass through the same shifter and bitwise logic, and during that pass the operand routing is switched. A single shifter with one-bit extension and a small bitwise-logic unit therefore serve both cycles, so no full-width double datapath is needed.

The surrounding pipeline pulses `start_i` together with an opcode and the three operands. It must keep the operands stable through the following cycle. The unit raises `busy_o` during the first cycle so that the pipeline stalls. In the second cycle it raises `valid_o` for one cycle and drives the result.

Top module: `tbm_ternary_unit`

## Requirements
- R1: A start accepted in cycle 1 raises `busy_o` in that same cycle and only in that cycle. `valid_o` is high in exactly the next cycle (cycle 2), for one cycle only. The operands must be held through cycle 2.
- R2: Opcode 0 (conditional mix) returns (rs1 AND rs2) OR (rs3 AND NOT rs2).
- R3: Opcode 1 (conditional move) returns rs1 when rs2 is nonzero and rs3 when rs2 is zero.
- R4: Opcode 2 (rotate left) and opcode 3 (rotate right) rotate rs1 by rs2 mod 32. An amount of 0 returns rs1 unchanged.
- R5: Opcode 5 (funnel shift right) returns the low 32 bits of {rs3,rs1} shifted right by rs2 mod 64. For amounts of 32 or more, the roles of rs1 and rs3 swap and the shift is by the amount minus 32.
- R6: Opcode 4 (funnel shift left) returns the high 32 bits of {rs1,rs3} shifted left by rs2 mod 64. For amounts of 32 or more, the roles of rs1 and rs3 swap and the shift is by the amount minus 32.
- R7: A funnel shift by exactly 0 returns rs1, and a funnel shift by exactly 32 returns rs3.
- R8: A start during cycle 2 is ignored: no new operation begins and `valid_o` is low in the next cycle. The opcode is captured at the start, so a change on `op_i` during cycle 2 does not alter the result.
- R9: Opcodes 6 and 7 still take two cycles and return zero. `result_o` is zero whenever `valid_o` is low.
- R10: After reset, `busy_o` and `valid_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one operation |
| op_i | input | 3 | Opcode (0 mix, 1 move, 2 rotl, 3 rotr, 4 funnel left, 5 funnel right) |
| src_a_i | input | 32 | Source operand rs1 |
| src_b_i | input | 32 | Source operand rs2 (condition, mask or shift amount) |
| src_c_i | input | 32 | Source operand rs3 |
| busy_o | output | 1 | Stall request, high in cycle 1 |
| valid_o | output | 1 | Result strobe, high in cycle 2 |
| result_o | output | 32 | Result, zero when not valid |

## Verification
Funnel shifts are swept through all 64 amounts in both directions with random operands. This separates the low half from the high half, where the operand roles swap, and it isolates the masked complement at 0 and 32. Rotates are swept through all 32 amounts, and any error in the complement path shows up at amount 0 and its neighbours. Conditional move is tried with rs2 zero and nonzero, and conditional mix with random masks, so that the stage-register half can be told apart from the second-cycle half. A start pulse with a different opcode during cycle 2 separates a latched opcode from a live one and shows whether the stray start is dropped.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
   typedef enum logic [2:0] {
      TBM_CMIX = 3'd0,
      TBM_CMOV = 3'd1,
      TBM_ROL  = 3'd2,
      TBM_ROR  = 3'd3,
      TBM_FSL  = 3'd4,
      TBM_FSR  = 3'd5,
      TBM_RSV6 = 3'd6,
      TBM_RSV7 = 3'd7
   } tbm_op_e;
endpackage

// File: rtl/tbm_shifter.sv
// Shifter shared by both cycles: a W-bit operand plus one fill bit,
// left shifts done by bit reversal around a right shifter.
module tbm_shifter #(
   parameter int W   = 32,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  x_i,
   input  logic [SW-1:0] amt_i,
   input  logic          left_i,
   input  logic          fill_i,
   output logic [W-1:0]  y_o
);
   logic [W-1:0] x_rev, pre, shr, shr_rev;

   always_comb begin
      for (int i = 0; i < W; i++) begin
         x_rev[i] = x_i[W-1-i];
      end
   end

   assign pre = left_i ? x_rev : x_i;
   // Equivalent to a (W+1)-bit arithmetic shift of {fill, pre}.
   assign shr = (pre >> amt_i) | (fill_i ? ~({W{1'b1}} >> amt_i) : '0);

   always_comb begin
      for (int i = 0; i < W; i++) begin
         shr_rev[i] = shr[W-1-i];
      end
   end

   assign y_o = left_i ? shr_rev : shr;
endmodule

// File: rtl/tbm_bitlogic.sv
// Bitwise logic shared with single-cycle operations.
module tbm_bitlogic #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] and_o,
   output logic [W-1:0] andn_o
);
   assign and_o  = a_i & b_i;
   assign andn_o = a_i & ~b_i;
endmodule

// File: rtl/tbm_ternary_unit.sv
module tbm_ternary_unit
   import tbm_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW = $clog2(WIDTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] src_a_i,
   input  logic [WIDTH-1:0] src_b_i,
   input  logic [WIDTH-1:0] src_c_i,
   output logic             busy_o,
   output logic             valid_o,
   output logic [WIDTH-1:0] result_o
);
   generate
      if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("tbm_ternary_unit: WIDTH must be a power of two of at least 4");
      end
   endgenerate

   logic             phase_q;
   tbm_op_e          op_q;
   logic [WIDTH-1:0] stage_q, stage_d, res;
   logic             accept;
   tbm_op_e          cur_op;
   logic             is_tern;
   logic [WIDTH-1:0] opnd_a;
   logic [SHW-1:0]   amt_t, amt_c, sh_amt;
   logic             amt_hi, first_t, t_right, use_t, sh_left;
   logic [WIDTH-1:0] sh_y, sh_term, bw_and, bw_andn;

   assign accept = start_i & ~phase_q;
   assign cur_op = phase_q ? op_q : tbm_op_e'(op_i);
   assign is_tern = (cur_op == TBM_CMIX) || (cur_op == TBM_CMOV) ||
                    (cur_op == TBM_FSL)  || (cur_op == TBM_FSR);
   // Cycle 2 of a ternary op routes rs3 where rs1 went in cycle 1.
   assign opnd_a = (phase_q && is_tern) ? src_c_i : src_a_i;

   assign amt_t  = src_b_i[SHW-1:0];
   assign amt_c  = SHW'(0) - amt_t;
   assign amt_hi = src_b_i[SHW];

   always_comb begin
      first_t = 1'b1;
      if (cur_op == TBM_FSL || cur_op == TBM_FSR) first_t = ~amt_hi;
   end

   assign t_right = (cur_op == TBM_ROR) || (cur_op == TBM_FSR);
   assign use_t   = first_t ^ phase_q;
   assign sh_amt  = use_t ? amt_t : amt_c;
   assign sh_left = use_t ? ~t_right : t_right;

   tbm_shifter #(.W(WIDTH)) u_shift (
      .x_i   (opnd_a),
      .amt_i (sh_amt),
      .left_i(sh_left),
      .fill_i(1'b0),
      .y_o   (sh_y)
   );

   // The complement pass contributes nothing when the amount is zero.
   assign sh_term = (!use_t && amt_t == '0) ? '0 : sh_y;

   tbm_bitlogic #(.W(WIDTH)) u_bw (
      .a_i   (opnd_a),
      .b_i   (src_b_i),
      .and_o (bw_and),
      .andn_o(bw_andn)
   );

   always_comb begin
      unique case (cur_op)
         TBM_CMIX:                          stage_d = bw_and;
         TBM_CMOV:                          stage_d = src_a_i;
         TBM_ROL, TBM_ROR, TBM_FSL, TBM_FSR: stage_d = sh_term;
         default:                           stage_d = '0;
      endcase
   end

   always_comb begin
      unique case (op_q)
         TBM_CMIX:                          res = stage_q | bw_andn;
         TBM_CMOV:                          res = (|src_b_i) ? stage_q : src_c_i;
         TBM_ROL, TBM_ROR, TBM_FSL, TBM_FSR: res = stage_q | sh_term;
         default:                           res = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= 1'b0;
         op_q    <= TBM_CMIX;
         stage_q <= '0;
      end else begin
         phase_q <= accept;
         if (accept) begin
            op_q    <= tbm_op_e'(op_i);
            stage_q <= stage_d;
         end
      end
   end

   assign busy_o   = accept;
   assign valid_o  = phase_q;
   assign result_o = phase_q ? res : '0;

   assert_two_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> valid_o);
   assert_single_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);
   assert_ignore_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && start_i) |=> !valid_o);
   assert_cmov_take_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && op_i == 3'd1 && src_b_i != '0) |=> (result_o == $past(src_a_i)));
   assert_funnel_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && (op_i == 3'd4 || op_i == 3'd5) && src_b_i[SHW:0] == '0)
      |=> (result_o == $past(src_a_i)));
endmodule

// File: tb/tbm_ternary_unit_tb_top.sv
module tbm_ternary_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] a = '0, b = '0, c = '0;
   logic        busy, valid;
   logic [31:0] result;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   tbm_ternary_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
      .src_a_i(a), .src_b_i(b), .src_c_i(c),
      .busy_o(busy), .valid_o(valid), .result_o(result)
   );

   function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] x,
                                         input logic [31:0] y, input logic [31:0] z);
      logic [63:0] v;
      int s;
      case (o)
         3'd0: return (x & y) | (z & ~y);
         3'd1: return (y != 0) ? x : z;
         3'd2: begin s = int'(y[4:0]); v = {x, x} << s; return v[63:32]; end
         3'd3: begin s = int'(y[4:0]); v = {x, x} >> s; return v[31:0]; end
         3'd4: begin
            s = int'(y[5:0]);
            if (s >= 32) begin v = {z, x}; s = s - 32; end else v = {x, z};
            v = v << s; return v[63:32];
         end
         3'd5: begin
            s = int'(y[5:0]);
            if (s >= 32) begin v = {x, z}; s = s - 32; end else v = {z, x};
            v = v >> s; return v[31:0];
         end
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // One operation: cycle 1 checks the stall, cycle 2 the result.
   task automatic run_op(input string req, input logic [2:0] o, input logic [31:0] x,
                         input logic [31:0] y, input logic [31:0] z);
      @(negedge clk);
      start = 1'b1; op = o; a = x; b = y; c = z;
      #1;
      check({req, " R1 busy"}, 32'(busy), 32'd1);
      check({req, " R1 no early valid"}, 32'(valid), 32'd0);
      @(negedge clk);
      start = 1'b0;
      #1;
      check({req, " R1 valid"}, 32'(valid), 32'd1);
      check({req, " result"}, result, model(o, x, y, z));
      @(negedge clk);
      #1;
      check({req, " R1 strobe ends"}, 32'(valid), 32'd0);
      check({req, " R9 idle zero"}, result, 32'd0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R10 busy", 32'(busy), 32'd0);
      check("R10 valid", 32'(valid), 32'd0);
      check("R10 result", result, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < 20; i++) run_op("R2 cmix", 3'd0, $urandom, $urandom, $urandom);
      run_op("R2 cmix all-ones mask", 3'd0, $urandom, 32'hFFFF_FFFF, $urandom);
      run_op("R2 cmix zero mask", 3'd0, $urandom, 32'd0, $urandom);
      run_op("R3 cmov zero cond", 3'd1, 32'h1234_5678, 32'd0, 32'h9ABC_DEF0);
      run_op("R3 cmov bit31 cond", 3'd1, 32'h1234_5678, 32'h8000_0000, 32'h9ABC_DEF0);
      for (int i = 0; i < 10; i++) run_op("R3 cmov", 3'd1, $urandom, $urandom, $urandom);
      for (int s = 0; s < 32; s++) begin
         run_op("R4 rotl", 3'd2, $urandom, 32'(s) | ($urandom & 32'hFFFF_FFE0), $urandom);
         run_op("R4 rotr", 3'd3, $urandom, 32'(s) | ($urandom & 32'hFFFF_FFE0), $urandom);
      end
      for (int s = 0; s < 64; s++) begin
         run_op("R5 fsr", 3'd5, $urandom, 32'(s) | ($urandom & 32'hFFFF_FFC0), $urandom);
         run_op("R6 fsl", 3'd4, $urandom, 32'(s) | ($urandom & 32'hFFFF_FFC0), $urandom);
      end
      run_op("R7 fsr amount 0", 3'd5, 32'hAAAA_0001, 32'd0, 32'h5555_0002);
      run_op("R7 fsr amount 32", 3'd5, 32'hAAAA_0001, 32'd32, 32'h5555_0002);
      run_op("R7 fsl amount 0", 3'd4, 32'hAAAA_0001, 32'd64, 32'h5555_0002);
      run_op("R7 fsl amount 32", 3'd4, 32'hAAAA_0001, 32'd96, 32'h5555_0002);
      run_op("R9 opcode 6", 3'd6, $urandom, $urandom, $urandom);
      run_op("R9 opcode 7", 3'd7, $urandom, $urandom, $urandom);

      // R8: stray start with a new opcode in cycle 2.
      @(negedge clk);
      start = 1'b1; op = 3'd3; a = 32'h0000_00F1; b = 32'd4; c = 32'h1;
      @(negedge clk);
      op = 3'd0;
      #1;
      check("R8 opcode latched", result, model(3'd3, 32'h0000_00F1, 32'd4, 32'h1));
      check("R8 no stall in cycle 2", 32'(busy), 32'd0);
      @(negedge clk);
      start = 1'b0;
      #1;
      check("R8 stray start dropped", 32'(valid), 32'd0);
      check("R8 result idle", result, 32'd0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule